// File: doc/BRIEF.md
# Flash Parallel Programming Controller

This block is the device-side sequencer for byte-wide parallel programming of a 2K-byte on-chip flash array. An external programmer raises a high-voltage enable, selects an operation on a 4-bit mode bus, and issues an active-low strobe. Instead of an address bus, an internal 11-bit counter selects the byte. A rising edge on an advance input moves the counter on by one, and a hardware reset returns it to zero.

The block carries out timed byte programs, verify reads, a timed chip erase, lock-bit programming and a two-byte identity readout. A busy flag and a polling bit on the data output show that a write is in progress. The array is a register-file model. A program only clears bits, because the new data is ANDed into the old contents. Program and erase times are parameters counted in clock cycles. Two nonvolatile lock bits restrict further writes and readout, and only a chip erase clears them. Neither lock bit can be read back.

Top module: `flash_prog_ctrl`

## Requirements
- R1: The address counter is zero after reset. Each rising edge seen on `adv` adds one, and the counter wraps from 7FFh to 000h.
- R2: With `hv_en` high and `mode` = 4'h1 (write), a falling edge of `strobe_n` starts a byte program of `din` at the current address. `ready` goes low in the cycle after the edge is sampled and stays low for exactly PROG_CYC cycles. Strobes that arrive while busy are ignored.
- R3: While a program is running, `dout` is 8'h00 with bit 7 replaced by the inverse of bit 7 of the byte being written. Once the program completes, write mode shows the stored byte, so bit 7 takes its true value.
- R4: With `hv_en` high, `ready` high and `mode` = 4'h2 (verify), `dout` is the byte at the current address.
- R5: With `mode` = 4'h6 (identity), `dout` is 8'h1E at address 0, 8'h21 at address 1, and 8'h00 at any other address.
- R6: With `mode` = 4'h3 (erase), holding `strobe_n` low for ERASE_CYC consecutive sampled cycles sets every byte to 8'hFF and clears both lock bits. A shorter hold changes nothing.
- R7: A strobe in mode 4'h4 sets lock bit 1, after which byte programs are ignored: `ready` stays high and the array is unchanged. A strobe in mode 4'h5 sets lock bit 2, after which verify and write mode both read 8'hFF.
- R8: A program stores the old byte ANDed with the new byte, so a bit that has been cleared stays cleared until the next erase.
- R9: With `hv_en` low, strobes start nothing and `dout` is 8'hFF. Any mode code not listed above also reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| hv_en | input | 1 | Programming voltage present; enables every operation |
| strobe_n | input | 1 | Active-low program/erase strobe |
| mode | input | 4 | Operation select |
| adv | input | 1 | Address advance; acts on its rising edge |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, identity bytes or polling status |
| ready | output | 1 | High when idle, low during a byte program |

## Verification
The bench counts the busy window cycle by cycle. A design that is off by one, or that never times out, fails on the measured length. It checks the polling bit for both values of bit 7, because a design that passes bit 7 through unchanged would look correct on only one of the two. It holds the erase strobe for one cycle less than ERASE_CYC and then for the full count: a design that compares against the wrong count erases early or never erases. The bench also overwrites programmed bytes, which exposes a design that stores the new data instead of ANDing it. It walks the counter through the 7FFh wrap, and it confirms that each lock bit takes effect and that only a chip erase releases it.

// File: rtl/flash_prog_ctrl.sv
`timescale 1ns/1ps
module flash_prog_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int PROG_CYC  = 40,
  parameter int ERASE_CYC = 120,
  parameter logic [7:0] MFR_ID = 8'h1E,
  parameter logic [7:0] DEV_ID = 8'h21
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hv_en,
  input  logic       strobe_n,
  input  logic [3:0] mode,
  input  logic       adv,
  input  logic [7:0] din,
  output logic [7:0] dout,
  output logic       ready
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  localparam logic [3:0] M_WRITE = 4'h1;
  localparam logic [3:0] M_READ  = 4'h2;
  localparam logic [3:0] M_ERASE = 4'h3;
  localparam logic [3:0] M_LOCK1 = 4'h4;
  localparam logic [3:0] M_LOCK2 = 4'h5;
  localparam logic [3:0] M_IDENT = 4'h6;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addr, wr_addr;
  logic [7:0]        wr_data;
  logic              strobe_q, adv_q, busy, edone, lock1, lock2;
  logic [CNT_W-1:0]  pcnt, ecnt;

  wire stb_fall   = hv_en & strobe_q & ~strobe_n & ~busy;
  wire start_wr   = stb_fall & (mode == M_WRITE) & ~lock1;
  wire wr_done    = busy & (pcnt == CNT_W'(PROG_CYC - 1));
  wire erase_hold = hv_en & (mode == M_ERASE) & ~strobe_n & ~busy & ~edone;
  wire erase_fire = erase_hold & (ecnt == CNT_W'(ERASE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr     <= '0;
      strobe_q <= 1'b1;
      adv_q    <= 1'b0;
      busy     <= 1'b0;
      pcnt     <= '0;
      wr_addr  <= '0;
      wr_data  <= 8'hFF;
      ecnt     <= '0;
      edone    <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      adv_q    <= adv;
      if (adv & ~adv_q) addr <= addr + 1'b1;
      if (start_wr) begin
        busy    <= 1'b1;
        pcnt    <= '0;
        wr_addr <= addr;
        wr_data <= din;
      end else if (wr_done) begin
        busy <= 1'b0;
      end else if (busy) begin
        pcnt <= pcnt + 1'b1;
      end
      if (strobe_n || !hv_en || mode != M_ERASE) begin
        ecnt  <= '0;
        edone <= 1'b0;
      end else if (erase_fire) begin
        ecnt  <= '0;
        edone <= 1'b1;
      end else if (erase_hold) begin
        ecnt <= ecnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (erase_fire) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (wr_done) begin
      mem[wr_addr] <= mem[wr_addr] & wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (erase_fire) begin
      lock1 <= 1'b0;
      lock2 <= 1'b0;
    end else if (stb_fall) begin
      if (mode == M_LOCK1) lock1 <= 1'b1;
      if (mode == M_LOCK2) lock2 <= 1'b1;
    end
  end

  assign ready = ~busy;

  always_comb begin
    dout = 8'hFF;
    if (busy) begin
      dout = {~wr_data[7], 7'h00};
    end else if (hv_en) begin
      case (mode)
        M_READ, M_WRITE: dout = lock2 ? 8'hFF : mem[addr];
        M_IDENT: begin
          if (addr == ADDR_W'(0))      dout = MFR_ID;
          else if (addr == ADDR_W'(1)) dout = DEV_ID;
          else                         dout = 8'h00;
        end
        default: dout = 8'hFF;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_ctrl_chk.sv
`timescale 1ns/1ps
module flash_prog_ctrl_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hv_en,
  input logic              strobe_n,
  input logic [3:0]        mode,
  input logic              adv,
  input logic [7:0]        din,
  input logic [7:0]        dout,
  input logic              ready,
  input logic [ADDR_W-1:0] addr,
  input logic              lock1,
  input logic              lock2
);
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adv) |=> addr == $past(addr) + 1'b1);                          // R1

  AST_POLL_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> dout == {~$past(din[7]), 7'h00});                    // R3

  AST_IDENT_MFR: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en && ready && mode == 4'h6 && addr == '0) |-> dout == 8'h1E);    // R5

  AST_LOCK1_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock1 && ready && mode == 4'h1 && $fell(strobe_n)) |=> ready);       // R7

  AST_LOCK2_HIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_en && ready && mode == 4'h2 && lock2) |-> dout == 8'hFF);          // R7

  AST_HV_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hv_en && ready) |=> ready);                                          // R9
endmodule

bind flash_prog_ctrl flash_prog_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .strobe_n(strobe_n), .mode(mode),
  .adv(adv), .din(din), .dout(dout), .ready(ready), .addr(addr),
  .lock1(lock1), .lock2(lock2)
);

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/1ps
module test_flash_prog_ctrl;
  localparam int PROG_CYC  = 40;
  localparam int ERASE_CYC = 120;

  logic clk = 1'b0, rst_n = 1'b0, hv_en = 1'b1, strobe_n = 1'b1, adv = 1'b0;
  logic [3:0] mode = 4'h0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       ready;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  flash_prog_ctrl #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .hv_en(hv_en), .strobe_n(strobe_n), .mode(mode),
    .adv(adv), .din(din), .dout(dout), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; adv = 1'b0; strobe_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic adv_pulse();
    adv = 1'b1; @(negedge clk);
    adv = 1'b0; @(negedge clk);
  endtask

  task automatic goto_addr(input int n);
    do_reset();
    for (int i = 0; i < n; i++) adv_pulse();
  endtask

  task automatic read_mode(input logic [3:0] m, output logic [7:0] v);
    mode = m; @(negedge clk); v = dout;
  endtask

  task automatic write_byte(input logic [7:0] d, output int blen, output logic [7:0] poll);
    mode = 4'h1; din = d; strobe_n = 1'b0;
    @(negedge clk);
    strobe_n = 1'b1;
    poll = dout;
    blen = 0;
    while (!ready && blen < 10000) begin blen++; @(negedge clk); end
  endtask

  task automatic strobe_op(input logic [3:0] m);
    mode = m; strobe_n = 1'b0; @(negedge clk);
    strobe_n = 1'b1; @(negedge clk);
  endtask

  task automatic erase_for(input int n);
    mode = 4'h3; strobe_n = 1'b0;
    repeat (n) @(negedge clk);
    strobe_n = 1'b1; @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    chk(ready === 1'b1, "R2 ready after reset", ready, 1);
    read_mode(4'h6, v); chk(v === 8'h1E, "R1 R5 ident at addr 0", v, 8'h1E);
    adv_pulse();
    read_mode(4'h6, v); chk(v === 8'h21, "R1 R5 ident at addr 1", v, 8'h21);
    adv_pulse();
    read_mode(4'h6, v); chk(v === 8'h00, "R5 ident at addr 2", v, 8'h00);
  endtask

  task automatic t_erase_blank();
    logic [7:0] v;
    goto_addr(0);
    erase_for(ERASE_CYC + 2);
    read_mode(4'h2, v); chk(v === 8'hFF, "R6 erased byte", v, 8'hFF);
  endtask

  task automatic t_program();
    logic [7:0] v, poll; int blen;
    goto_addr(0);
    write_byte(8'hA5, blen, poll);
    chk(poll === 8'h00, "R3 polling bit7 set data", poll, 8'h00);
    chk(blen == PROG_CYC, "R2 busy length", blen, PROG_CYC);
    chk(dout === 8'hA5, "R3 write view after done", dout, 8'hA5);
    read_mode(4'h2, v); chk(v === 8'hA5, "R4 verify A5", v, 8'hA5);
    goto_addr(5);
    write_byte(8'h3C, blen, poll);
    chk(poll === 8'h80, "R3 polling bit7 clear data", poll, 8'h80);
    chk(blen == PROG_CYC, "R2 busy length second", blen, PROG_CYC);
    read_mode(4'h2, v); chk(v === 8'h3C, "R4 verify 3C", v, 8'h3C);
  endtask

  task automatic t_and();
    logic [7:0] v, poll; int blen;
    goto_addr(0);
    write_byte(8'hF0, blen, poll);
    read_mode(4'h2, v); chk(v === 8'hA0, "R8 and into A5", v, 8'hA0);
    goto_addr(5);
    write_byte(8'hFF, blen, poll);
    read_mode(4'h2, v); chk(v === 8'h3C, "R8 ones keep zeros", v, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v; int blen;
    goto_addr(7);
    mode = 4'h1; din = 8'h55; strobe_n = 1'b0; @(negedge clk);
    strobe_n = 1'b1; @(negedge clk);
    din = 8'h00; strobe_n = 1'b0; @(negedge clk);
    strobe_n = 1'b1;
    blen = 2;
    while (!ready && blen < 10000) begin blen++; @(negedge clk); end
    chk(blen == PROG_CYC, "R2 second strobe ignored length", blen, PROG_CYC);
    read_mode(4'h2, v); chk(v === 8'h55, "R2 second strobe ignored data", v, 8'h55);
  endtask

  task automatic t_wrap();
    logic [7:0] v;
    goto_addr(2047);
    read_mode(4'h2, v); chk(v === 8'hFF, "R1 top address blank", v, 8'hFF);
    adv_pulse();
    read_mode(4'h2, v); chk(v === 8'hA0, "R1 wrap to 000", v, 8'hA0);
  endtask

  task automatic t_short_erase();
    logic [7:0] v;
    goto_addr(0);
    erase_for(ERASE_CYC - 1);
    read_mode(4'h2, v); chk(v === 8'hA0, "R6 short hold no erase", v, 8'hA0);
  endtask

  task automatic t_hv_off();
    logic [7:0] v;
    goto_addr(0);
    hv_en = 1'b0; mode = 4'h1; din = 8'h00; strobe_n = 1'b0; @(negedge clk);
    strobe_n = 1'b1;
    chk(ready === 1'b1, "R9 no busy without hv", ready, 1);
    chk(dout === 8'hFF, "R9 dout without hv", dout, 8'hFF);
    @(negedge clk); hv_en = 1'b1;
    read_mode(4'h2, v); chk(v === 8'hA0, "R9 byte untouched", v, 8'hA0);
    read_mode(4'h7, v); chk(v === 8'hFF, "R9 unused mode", v, 8'hFF);
  endtask

  task automatic t_lock1();
    logic [7:0] v, poll; int blen;
    goto_addr(1);
    strobe_op(4'h4);
    write_byte(8'h00, blen, poll);
    chk(blen == 0, "R7 lock1 no busy", blen, 0);
    read_mode(4'h2, v); chk(v === 8'hFF, "R7 lock1 write ignored", v, 8'hFF);
    goto_addr(0);
    read_mode(4'h2, v); chk(v === 8'hA0, "R7 lock1 verify allowed", v, 8'hA0);
  endtask

  task automatic t_lock2();
    logic [7:0] v;
    goto_addr(0);
    strobe_op(4'h5);
    read_mode(4'h2, v); chk(v === 8'hFF, "R7 lock2 verify hidden", v, 8'hFF);
    read_mode(4'h6, v); chk(v === 8'h1E, "R5 ident under lock", v, 8'h1E);
  endtask

  task automatic t_erase_unlock();
    logic [7:0] v, poll; int blen;
    goto_addr(0);
    erase_for(ERASE_CYC);
    read_mode(4'h2, v); chk(v === 8'hFF, "R6 erase exact count", v, 8'hFF);
    write_byte(8'h12, blen, poll);
    chk(blen == PROG_CYC, "R6 locks cleared write runs", blen, PROG_CYC);
    read_mode(4'h2, v); chk(v === 8'h12, "R6 locks cleared verify", v, 8'h12);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_erase_blank();
    t_program();
    t_and();
    t_busy_ignore();
    t_wrap();
    t_short_erase();
    t_hv_off();
    t_lock1();
    t_lock2();
    t_erase_unlock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule